// File: doc/BRIEF.md
# Frame and Burst Timing Sequencer

This block is the central sequencer of a time-division duplex controller. It turns an enable level and a sync pulse into a stream of equal-length frames, and gives the channel generators a frame-position count to compare their switching points against. Between the sync pulse and the first frame it inserts a programmable startup delay. It then plays a programmed number of frames, or keeps playing for as long as it stays enabled when that number is zero.

The sequencer has four named states: IDLE (encoding 0), ARMED (1), WAITING (2) and RUNNING (3). These are the transitions:
- IDLE→ARMED when enable is high and no finite burst has completed since enable last went low.
- ARMED→WAITING on a sync pulse.
- WAITING→RUNNING when the startup delay count expires.
- RUNNING→IDLE after the final frame of a finite burst.
- Any state→IDLE one cycle after enable is low.

When resynchronisation is allowed, a sync pulse seen in WAITING or RUNNING forces the shared counter back to zero without changing the state. Frame length, burst length and startup delay are captured into holding registers only in cycles where enable is low. Changing them while the block is enabled has no effect.

Top module: `tdd_frame_sequencer`

## Requirements
- R1: After reset the state is IDLE (state_out = 0), frame_pos is 0, and frame_end, armed and running are low.
- R2: One cycle after enable is first seen high in IDLE the state is ARMED (armed high). ARMED holds for as long as no sync pulse arrives. A sync pulse while disabled leaves the state IDLE.
- R3: A sync pulse in ARMED moves the state to WAITING on the next cycle. WAITING lasts exactly start_delay+1 cycles, after which the state is RUNNING with frame_pos 0.
- R4: In RUNNING, frame_pos counts 0,1,…,L-1 and then wraps to 0, where L is the frame length and a length of 0 is treated as 1. frame_end is high in exactly the cycle where frame_pos is L-1. Outside RUNNING, frame_pos is 0 and frame_end is low.
- R5: With a burst length B>0 the block plays exactly B frames and is IDLE in the cycle after the last frame_end. It stays IDLE while enable stays high.
- R6: With a burst length of 0, frames repeat without end for as long as enable stays high.
- R7: Enable low in any state gives IDLE on the next cycle.
- R8: With sync_rst_en high, a sync pulse in RUNNING makes frame_pos 0 on the next cycle and does not change how many frames of the burst remain. In WAITING it restarts the full start_delay+1 wait.
- R9: With sync_rst_en low, a sync pulse in WAITING or RUNNING has no effect on the counting.
- R10: Frame length, burst length and startup delay are taken only in cycles where enable is low. New values applied while enabled leave the running sequence unchanged.
- R11: armed is high only in ARMED and running is high only in RUNNING. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Operation enable level |
| sync_pulse | input | 1 | Combined synchronisation pulse |
| sync_rst_en | input | 1 | Allow sync to zero the counter in WAITING/RUNNING |
| cfg_frame_len | input | CNT_W | Counts per frame |
| cfg_burst_len | input | BURST_W | Frames per burst, 0 = endless |
| cfg_start_delay | input | CNT_W | Startup delay in cycles |
| frame_pos | output | CNT_W | Position inside the current frame |
| frame_end | output | 1 | High in the last cycle of each frame |
| state_out | output | 2 | Current state encoding |
| armed | output | 1 | High in ARMED |
| running | output | 1 | High in RUNNING |

## Verification
The hardest situations to reach are resynchronisation pulses that land at a chosen counter value. Examples are a pulse in the middle of the second frame of a two-frame burst, or a pulse partway through a startup delay. Both decide whether the burst tally and the delay restart behave correctly. The bench drives the sequence one cycle at a time from the moment of the sync pulse, so it knows the exact counter value. It then raises the pulse on the chosen cycle and counts the remaining frames or wait cycles. The main function is covered by a sweep of every small frame length, burst length and delay.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WAITING = 2'd2,
        ST_RUNNING = 2'd3
    } seq_state_t;
endpackage

// File: rtl/tdd_cfg_hold.sv
// Holding registers: follow the configuration only while disabled.
module tdd_cfg_hold #(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [CNT_W-1:0]   frame_len_i,
    input  logic [BURST_W-1:0] burst_len_i,
    input  logic [CNT_W-1:0]   start_delay_i,
    output logic [CNT_W-1:0]   frame_len_o,
    output logic [BURST_W-1:0] burst_len_o,
    output logic [CNT_W-1:0]   start_delay_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len_o   <= '0;
            burst_len_o   <= '0;
            start_delay_o <= '0;
        end else if (!enable) begin
            frame_len_o   <= frame_len_i;
            burst_len_o   <= burst_len_i;
            start_delay_o <= start_delay_i;
        end
    end
endmodule

// File: rtl/tdd_pos_counter.sv
// Shared counter: startup delay in WAITING, frame position in RUNNING.
module tdd_pos_counter
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic             clear,
    input  logic             sync_rst_hit,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] start_delay,
    output logic [CNT_W-1:0] cnt_q,
    output logic             frame_last,
    output logic             delay_done
);
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] cnt_d;

    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    // A length of zero behaves as a length of one.
    assign frame_last = (state == ST_RUNNING) && (cnt_inc >= {1'b0, frame_len});
    assign delay_done = (state == ST_WAITING) && (cnt_q == start_delay) && !sync_rst_hit;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else begin
            unique case (state)
                ST_WAITING: cnt_d = (sync_rst_hit || delay_done) ? '0 : cnt_inc[CNT_W-1:0];
                ST_RUNNING: cnt_d = (sync_rst_hit || frame_last) ? '0 : cnt_inc[CNT_W-1:0];
                default:    cnt_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tdd_frame_tally.sv
// Counts completed frames of a burst and flags the last one.
module tdd_frame_tally #(
    parameter int BURST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               frame_done,
    input  logic [BURST_W-1:0] burst_len,
    output logic               last_frame
);
    logic [BURST_W-1:0] frames_q;

    assign last_frame = (burst_len != '0) && (frames_q == burst_len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) frames_q <= '0;
        else if (frame_done) frames_q <= frames_q + 1'b1;
    end
endmodule

// File: rtl/tdd_seq_ctrl.sv
// Four-state sequencer.
module tdd_seq_ctrl
    import tdd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sync_pulse,
    input  logic       delay_done,
    input  logic       frame_last,
    input  logic       last_frame,
    output seq_state_t state,
    output seq_state_t state_nxt,
    output logic       armed,
    output logic       running
);
    logic burst_done_q;
    logic burst_finish;

    assign burst_finish = (state == ST_RUNNING) && frame_last && last_frame;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (enable && !burst_done_q) state_nxt = ST_ARMED;
            ST_ARMED:   if (sync_pulse)              state_nxt = ST_WAITING;
            ST_WAITING: if (delay_done)              state_nxt = ST_RUNNING;
            ST_RUNNING: if (burst_finish)            state_nxt = ST_IDLE;
            default:                                 state_nxt = ST_IDLE;
        endcase
        if (!enable) state_nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            burst_done_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (!enable)           burst_done_q <= 1'b0;
            else if (burst_finish) burst_done_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        armed   = 1'b0;
        running = 1'b0;
        unique case (state)
            ST_ARMED:   armed   = 1'b1;
            ST_RUNNING: running = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/tdd_frame_sequencer.sv
module tdd_frame_sequencer
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sync_pulse,
    input  logic               sync_rst_en,
    input  logic [CNT_W-1:0]   cfg_frame_len,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic [CNT_W-1:0]   cfg_start_delay,
    output logic [CNT_W-1:0]   frame_pos,
    output logic               frame_end,
    output logic [1:0]         state_out,
    output logic               armed,
    output logic               running
);
    logic [CNT_W-1:0]   frame_len_h;
    logic [BURST_W-1:0] burst_len_h;
    logic [CNT_W-1:0]   start_delay_h;
    logic [CNT_W-1:0]   cnt_q;
    logic               frame_last;
    logic               delay_done;
    logic               last_frame;
    logic               sync_rst_hit;
    seq_state_t         state;
    seq_state_t         state_nxt;

    assign sync_rst_hit = sync_pulse && sync_rst_en;

    tdd_cfg_hold #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .frame_len_i(cfg_frame_len), .burst_len_i(cfg_burst_len),
        .start_delay_i(cfg_start_delay),
        .frame_len_o(frame_len_h), .burst_len_o(burst_len_h),
        .start_delay_o(start_delay_h)
    );

    tdd_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync_pulse(sync_pulse),
        .delay_done(delay_done), .frame_last(frame_last), .last_frame(last_frame),
        .state(state), .state_nxt(state_nxt), .armed(armed), .running(running)
    );

    tdd_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .state(state),
        .clear((state_nxt == ST_IDLE) || (state_nxt == ST_ARMED)),
        .sync_rst_hit(sync_rst_hit), .frame_len(frame_len_h),
        .start_delay(start_delay_h), .cnt_q(cnt_q),
        .frame_last(frame_last), .delay_done(delay_done)
    );

    tdd_frame_tally #(.BURST_W(BURST_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(state_nxt != ST_RUNNING),
        .frame_done(frame_last), .burst_len(burst_len_h),
        .last_frame(last_frame)
    );

    assign frame_pos = running ? cnt_q : '0;
    assign frame_end = frame_last;
    assign state_out = state;
endmodule

// File: rtl/tdd_seq_checker.sv
module tdd_seq_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sync_pulse,
    input logic             sync_rst_en,
    input logic [CNT_W-1:0] frame_pos,
    input logic             frame_end,
    input logic [1:0]       state_out,
    input logic             armed,
    input logic             running
);
    p_disable_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_out == 2'd0);

    p_armed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 2'd1 && enable && !sync_pulse) |=> state_out == 2'd1);

    p_armed_to_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 2'd1 && enable && sync_pulse) |=> state_out == 2'd2);

    p_run_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(state_out) == 2'd2 && frame_pos == '0));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (frame_pos == '0 && !frame_end));

    p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && !frame_end && !(sync_pulse && sync_rst_en))
        |=> frame_pos == $past(frame_pos) + 1'b1);

    p_sync_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && sync_pulse && sync_rst_en) |=> frame_pos == '0);

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, running}));
endmodule

bind tdd_frame_sequencer tdd_seq_checker #(.CNT_W(CNT_W)) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_pulse(sync_pulse),
    .sync_rst_en(sync_rst_en), .frame_pos(frame_pos), .frame_end(frame_end),
    .state_out(state_out), .armed(armed), .running(running)
);

// File: tb/test_tdd_frame_sequencer.sv
module test_tdd_frame_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sync_pulse = 1'b0;
    logic          sync_rst_en = 1'b0;
    logic [CW-1:0] cfg_frame_len = '0;
    logic [BW-1:0] cfg_burst_len = '0;
    logic [CW-1:0] cfg_start_delay = '0;
    logic [CW-1:0] frame_pos;
    logic          frame_end;
    logic [1:0]    state_out;
    logic          armed;
    logic          running;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdd_frame_sequencer #(.CNT_W(CW), .BURST_W(BW)) i_tdd_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync_pulse(sync_pulse),
        .sync_rst_en(sync_rst_en), .cfg_frame_len(cfg_frame_len),
        .cfg_burst_len(cfg_burst_len), .cfg_start_delay(cfg_start_delay),
        .frame_pos(frame_pos), .frame_end(frame_end), .state_out(state_out),
        .armed(armed), .running(running)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    // Encoding: IDLE 0, ARMED 1, WAITING 2, RUNNING 3
    task automatic chk_all(input string r, input int st, input int pos, input int fe);
        chk(r, "state", int'(state_out), st);
        chk(r, "frame_pos", int'(frame_pos), pos);
        chk(r, "frame_end", int'(frame_end), fe);
        chk(r, "armed", int'(armed), int'(st == 1));
        chk(r, "running", int'(running), int'(st == 3));
    endtask

    task automatic load_cfg(input int len, input int burst, input int dly);
        enable = 1'b0;
        cfg_frame_len = CW'(len);
        cfg_burst_len = BW'(burst);
        cfg_start_delay = CW'(dly);
        step();
        step();
    endtask

    task automatic arm_and_sync();
        enable = 1'b1;
        step();
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
    endtask

    task automatic finish_bench();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic run_burst(input int len, input int burst, input int dly);
        int eff;
        eff = (len == 0) ? 1 : len;
        sync_rst_en = 1'b1;
        load_cfg(len, burst, dly);
        enable = 1'b1;
        step();
        chk_all("R2", 1, 0, 0);
        step();
        chk_all("R2", 1, 0, 0);
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        for (int i = 0; i <= dly; i++) begin
            chk_all("R3", 2, 0, 0);
            step();
        end
        for (int f = 0; f < burst; f++) begin
            for (int p = 0; p < eff; p++) begin
                chk_all("R4", 3, p, int'(p == eff - 1));
                step();
            end
        end
        chk_all("R5", 0, 0, 0);
        step();
        step();
        chk_all("R5", 0, 0, 0);
        enable = 1'b0;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_bench();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk_all("R1", 0, 0, 0);

        // R2: sync while disabled is ignored
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        step();
        chk_all("R2", 0, 0, 0);

        // R3 R4 R5: sweep of small configurations (length 0 acts as 1)
        for (int len = 0; len <= 4; len++)
            for (int b = 1; b <= 3; b++)
                for (int d = 0; d <= 3; d++)
                    run_burst(len, b, d);

        // R6: endless burst, then R7 disable mid-frame
        sync_rst_en = 1'b0;
        load_cfg(3, 0, 1);
        arm_and_sync();
        step();
        step();
        for (int f = 0; f < 6; f++)
            for (int p = 0; p < 3; p++) begin
                chk_all("R6", 3, p, int'(p == 2));
                step();
            end
        step();
        chk_all("R6", 3, 1, 0);
        enable = 1'b0;
        step();
        chk_all("R7", 0, 0, 0);

        // R7: disable from ARMED and from WAITING
        load_cfg(3, 0, 4);
        enable = 1'b1;
        step();
        chk_all("R7", 1, 0, 0);
        enable = 1'b0;
        step();
        chk_all("R7", 0, 0, 0);
        arm_and_sync();
        step();
        chk_all("R7", 2, 0, 0);
        enable = 1'b0;
        step();
        chk_all("R7", 0, 0, 0);

        // R8: resync in RUNNING, endless
        sync_rst_en = 1'b1;
        load_cfg(8, 0, 0);
        arm_and_sync();
        step();
        step(); step(); step();
        chk_all("R8", 3, 3, 0);
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        chk_all("R8", 3, 0, 0);
        step();
        chk_all("R8", 3, 1, 0);
        // R9: resync disabled, pulse ignored in RUNNING
        sync_rst_en = 1'b0;
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        chk_all("R9", 3, 2, 0);
        enable = 1'b0;
        step();

        // R8: resync inside the second frame of a two-frame burst
        sync_rst_en = 1'b1;
        load_cfg(4, 2, 0);
        arm_and_sync();
        step();
        for (int p = 0; p < 4; p++) begin
            chk_all("R8", 3, p, int'(p == 3));
            step();
        end
        step();
        chk_all("R8", 3, 1, 0);
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        for (int p = 0; p < 4; p++) begin
            chk_all("R8", 3, p, int'(p == 3));
            step();
        end
        chk_all("R8", 0, 0, 0);
        enable = 1'b0;
        step();

        // R8: resync restarts the startup delay
        load_cfg(2, 1, 5);
        arm_and_sync();
        step();
        step();
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        for (int i = 0; i <= 5; i++) begin
            chk_all("R8", 2, 0, 0);
            step();
        end
        chk_all("R8", 3, 0, 0);
        enable = 1'b0;
        step();

        // R9: pulse in WAITING ignored when resync is off
        sync_rst_en = 1'b0;
        load_cfg(2, 1, 3);
        arm_and_sync();
        step();
        sync_pulse = 1'b1;
        step();
        sync_pulse = 1'b0;
        step();
        chk_all("R9", 2, 0, 0);
        step();
        chk_all("R9", 3, 0, 0);
        enable = 1'b0;
        step();

        // R10: configuration changes while enabled are ignored
        load_cfg(4, 0, 0);
        arm_and_sync();
        step();
        cfg_frame_len = CW'(6);
        cfg_burst_len = BW'(1);
        cfg_start_delay = CW'(3);
        for (int f = 0; f < 3; f++)
            for (int p = 0; p < 4; p++) begin
                chk_all("R10", 3, p, int'(p == 3));
                step();
            end
        enable = 1'b0;
        step();
        step();
        // R10: values taken while disabled now apply (length 6, one frame, delay 3)
        arm_and_sync();
        for (int i = 0; i <= 3; i++) begin
            chk_all("R10", 2, 0, 0);
            step();
        end
        for (int p = 0; p < 6; p++) begin
            chk_all("R10", 3, p, int'(p == 5));
            step();
        end
        chk_all("R11", 0, 0, 0);
        enable = 1'b0;
        step();

        finish_bench();
    end
endmodule